// File: doc/BRIEF.md
# Weighted-Fairness DMA Bus Arbiter

This block decides which requester owns a shared bus for the next transaction. The requesters are one processor port and a set of DMA channels. Each channel carries a 3-bit priority, where a smaller number is more urgent, and a bit that says whether it takes part in round-robin sharing within its level. The processor request beats every channel. Channels at levels 0 and 1 are served by strict priority and can hold the bus indefinitely. Levels 2 to 7 share what is left under a weighted scheme, so that even the least urgent level receives a small guaranteed share of the grants.

The weighting comes from a 6-bit slot counter. It steps once for every grant made to a level in the 2..7 range. The position of the lowest set bit of the count names the level that is favoured for the next grant, which gives level 2 half of the slots, level 3 a quarter, and so on down to level 7. A global enable turns the weighting off, and the arbiter then uses level order alone.

The owner keeps the bus until the transaction-done input is raised. Arbitration runs only when the bus is idle or on the cycle in which the current transaction ends. The grant is registered, so it appears one cycle later.

Top module: `dma_fair_arbiter`

## Requirements
- R1: Whenever arbitration runs and `cpu_req` is high, the next cycle shows `cpu_gnt` = 1 and `gnt_valid` = 0, whatever the channels request.
- R2: The grant outputs are registered and consistent. `gnt_onehot` has exactly bit `gnt_idx` set while `gnt_valid` is 1 and is all-zero otherwise. `cpu_gnt` and `gnt_valid` are never high together.
- R3: If any channel at level 0 requests, a level-0 channel is granted. Otherwise, if any channel at level 1 requests, a level-1 channel is granted. This holds whether or not fairness is enabled.
- R4: The 6-bit slot counter resets to 0 and steps by one (modulo 64) on each grant to a level from 2 to 7. With fairness enabled, the favoured level is 2 plus the index of the lowest set bit of the count, or level 7 when the count is 0. The favoured level is granted when it has a request and no level 0 or 1 request is present. With levels 2..7 requesting on every slot, 64 consecutive grants split as 32, 16, 8, 4, 2, 2 across levels 2 to 7.
- R5: With fairness enabled, if the favoured level has no request, the lowest-numbered requesting level is granted.
- R6: With fairness disabled (`fair_en` = 0), the lowest-numbered requesting level is always granted. The slot counter still steps as in R4.
- R7: Each level has a round-robin pointer that resets to channel 0. Among round-robin channels of a level, the grant goes to the first requester at or after the pointer, searching in increasing index order and wrapping. Granting round-robin channel c moves that level's pointer to c+1, wrapping to 0 after the last channel.
- R8: A requesting channel whose `ch_rr_en` bit is 0 is granted ahead of every round-robin channel of the same level. Among several such channels, the lowest index wins. Granting such a channel leaves the level's pointer unchanged.
- R9: Arbitration runs only when no grant is held, or in the cycle `xfer_done` is high. Otherwise all grant outputs hold their values. If nothing is requested when arbitration runs, all grant outputs go to 0.
- R10: While `rst_n` is low at a rising edge, all grant outputs clear to 0, the slot counter clears, and every pointer is set to channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor bus request |
| ch_req | input | NUM_CH | Per-channel DMA request |
| ch_prio | input | NUM_CH*3 | Per-channel priority level; channel c uses bits [3c+2:3c] |
| ch_rr_en | input | NUM_CH | Per-channel round-robin participation |
| fair_en | input | 1 | Enables weighted sharing for levels 2..7 |
| xfer_done | input | 1 | Current transaction ends this cycle |
| cpu_gnt | output | 1 | Processor owns the bus |
| gnt_onehot | output | NUM_CH | One-hot channel grant |
| gnt_valid | output | 1 | A channel owns the bus |
| gnt_idx | output | $clog2(NUM_CH) | Index of the granted channel |

## Verification
Two situations can land on the same edge, and the bench is built to produce both. The first is a transaction ending through `xfer_done` while a new processor request or a more urgent channel request is present. The bench raises `xfer_done` on roughly half the cycles and turns `cpu_req` and the level 0/1 priorities on at random, so a change of owner in the same cycle as the end of a transaction happens often. It is judged against a cycle model that re-arbitrates only on those cycles. The second is a pointer advance of one channel in the same level as a channel that has round-robin disabled. Mixed `ch_rr_en` patterns check that the head-of-line channel wins and that the pointer stays where it was. A 64-grant window with all six fair levels busy confirms the exact bandwidth split arithmetically.

// File: rtl/dfa_pkg.sv
// Shared constants and types for the weighted-fairness DMA arbiter.
// Assumes a 3-bit priority field; the strict levels are the lowest numbers.
package dfa_pkg;
    localparam int PRIO_W      = 3;
    localparam int NUM_LVL     = 1 << PRIO_W;
    localparam int STRICT_LVLS = 2;
    localparam int SLOT_W      = NUM_LVL - STRICT_LVLS;
    typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/dfa_slot_ctr.sv
// Slot counter for the weighted scheme: it steps once per grant that falls
// in the fair level range.
// Assumes the caller raises step for at most one grant per cycle.
module dfa_slot_ctr
    import dfa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [SLOT_W-1:0] slot
);
    // Count fair-range grants, wrapping naturally at 2**SLOT_W.
    always_ff @(posedge clk) begin
        if (!rst_n)    slot <= '0;
        else if (step) slot <= slot + 1'b1;
    end

    assert_slot_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> slot == $past(slot) + 1'b1);
    assert_slot_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(slot));
endmodule

// File: rtl/dfa_level_pick.sv
// Chooses the winning priority level from the per-level request summary.
// Strict levels win outright. With fairness on, the level favoured by the
// slot count wins when it has a request. Otherwise the most urgent level wins.
// Purely combinational.
module dfa_level_pick
    import dfa_pkg::*;
(
    input  logic [NUM_LVL-1:0] lvl_any,
    input  logic               fair_en,
    input  logic [SLOT_W-1:0]  slot,
    output logic               any,
    output prio_t              win_lvl
);
    prio_t top_lvl;
    prio_t fav_lvl;

    // Most urgent requesting level (lowest number).
    always_comb begin
        top_lvl = prio_t'(NUM_LVL - 1);
        for (int l = NUM_LVL - 1; l >= 0; l--)
            if (lvl_any[l]) top_lvl = prio_t'(l);
    end

    // Favoured level from the lowest set bit of the slot count.
    always_comb begin
        fav_lvl = prio_t'(NUM_LVL - 1);
        for (int b = SLOT_W - 1; b >= 0; b--)
            if (slot[b]) fav_lvl = prio_t'(STRICT_LVLS + b);
    end

    // Final level choice.
    always_comb begin
        any     = |lvl_any;
        win_lvl = top_lvl;
        if (fair_en && (top_lvl >= prio_t'(STRICT_LVLS)) && lvl_any[fav_lvl])
            win_lvl = fav_lvl;
    end
endmodule

// File: rtl/dfa_rr_pick.sv
// Picks one channel within a single priority level and keeps that level's
// round-robin pointer. Channels with round-robin disabled go to the head of
// the line, lowest index first. The pointer moves only past a granted
// round-robin channel.
// Assumes req already holds only the channels of this level.
module dfa_rr_pick #(
    parameter int N     = 24,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    input  logic [N-1:0]     rr_en,
    input  logic             adv,
    input  logic [IDX_W-1:0] adv_idx,
    output logic             hit,
    output logic [IDX_W-1:0] sel
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    logic [IDX_W-1:0] ptr;
    logic             head_hit;
    logic [IDX_W-1:0] head_idx;
    logic             rr_hit;
    logic [IDX_W-1:0] rr_idx;

    // Lowest-index requester that has opted out of round-robin.
    always_comb begin
        head_hit = 1'b0;
        head_idx = '0;
        for (int i = N - 1; i >= 0; i--)
            if (req[i] && !rr_en[i]) begin
                head_hit = 1'b1;
                head_idx = IDX_W'(i);
            end
    end

    // First requester at or after the pointer, with wrap.
    always_comb begin
        rr_hit = 1'b0;
        rr_idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int j;
            j = int'(ptr) + k;
            if (j >= N) j = j - N;
            if (req[j]) begin
                rr_hit = 1'b1;
                rr_idx = IDX_W'(j);
            end
        end
    end

    // Merge the head-of-line and rotating choices.
    always_comb begin
        hit = rr_hit;
        sel = head_hit ? head_idx : rr_idx;
    end

    // Advance the pointer past a granted round-robin channel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (adv && rr_en[adv_idx])
            ptr <= (adv_idx == LAST) ? '0 : adv_idx + 1'b1;
    end

    assert_ptr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST);
    assert_head_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        head_hit |-> (req[sel] && !rr_en[sel]));
    assert_head_keeps_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !rr_en[adv_idx]) |=> $stable(ptr));
endmodule

// File: rtl/dma_fair_arbiter.sv
// Bus arbiter for one processor port and NUM_CH DMA channels.
// The processor always wins. Levels 0 and 1 are strict. Levels 2..7 share the
// remaining slots by a slot-count weighting, or by level order when fairness
// is off. Grants are registered and change only when the bus is idle or
// xfer_done marks the end of the current transaction.
// Assumes xfer_done is raised for one cycle by the current owner.
module dma_fair_arbiter
    import dfa_pkg::*;
#(
    parameter int NUM_CH = 24,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_req,
    input  logic [NUM_CH-1:0]        ch_req,
    input  logic [NUM_CH*PRIO_W-1:0] ch_prio,
    input  logic [NUM_CH-1:0]        ch_rr_en,
    input  logic                     fair_en,
    input  logic                     xfer_done,
    output logic                     cpu_gnt,
    output logic [NUM_CH-1:0]        gnt_onehot,
    output logic                     gnt_valid,
    output logic [IDX_W-1:0]         gnt_idx
);
    logic [NUM_CH-1:0]  lvl_req  [NUM_LVL];
    logic [IDX_W-1:0]   pick_idx [NUM_LVL];
    logic [NUM_LVL-1:0] lvl_any;
    logic [NUM_LVL-1:0] lvl_adv;
    logic [SLOT_W-1:0]  slot;
    logic               dma_any;
    prio_t              win_lvl;
    prio_t              gnt_lvl;
    logic [IDX_W-1:0]   win_idx;
    logic               arb_ok;
    logic               do_dma;

    // Split the channel requests by their configured level.
    always_comb begin
        for (int l = 0; l < NUM_LVL; l++)
            for (int c = 0; c < NUM_CH; c++)
                lvl_req[l][c] = ch_req[c] && (ch_prio[c*PRIO_W +: PRIO_W] == prio_t'(l));
    end

    generate
        for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
            dfa_rr_pick #(.N(NUM_CH), .IDX_W(IDX_W)) u_rr (
                .clk     (clk),
                .rst_n   (rst_n),
                .req     (lvl_req[l]),
                .rr_en   (ch_rr_en),
                .adv     (lvl_adv[l]),
                .adv_idx (pick_idx[l]),
                .hit     (lvl_any[l]),
                .sel     (pick_idx[l])
            );
            assign lvl_adv[l] = do_dma && (win_lvl == prio_t'(l));
        end
    endgenerate

    dfa_level_pick u_lvl (
        .lvl_any (lvl_any),
        .fair_en (fair_en),
        .slot    (slot),
        .any     (dma_any),
        .win_lvl (win_lvl)
    );

    dfa_slot_ctr u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (do_dma && (win_lvl >= prio_t'(STRICT_LVLS))),
        .slot  (slot)
    );

    // Arbitration window and the winning channel.
    always_comb begin
        arb_ok  = !(cpu_gnt || gnt_valid) || xfer_done;
        do_dma  = arb_ok && !cpu_req && dma_any;
        win_idx = pick_idx[win_lvl];
    end

    // Register the grant at each arbitration point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_gnt    <= 1'b0;
            gnt_valid  <= 1'b0;
            gnt_idx    <= '0;
            gnt_onehot <= '0;
            gnt_lvl    <= '0;
        end else if (arb_ok) begin
            cpu_gnt    <= cpu_req;
            gnt_valid  <= do_dma;
            gnt_idx    <= do_dma ? win_idx : '0;
            gnt_onehot <= do_dma ? (NUM_CH'(1) << win_idx) : '0;
            gnt_lvl    <= win_lvl;
        end
    end

    assert_cpu_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_ok && cpu_req) |=> (cpu_gnt && !gnt_valid));
    assert_grant_form_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_gnt && gnt_valid) && $onehot0(gnt_onehot) &&
        (gnt_valid == (|gnt_onehot)) && (!gnt_valid || gnt_onehot[gnt_idx]));
    assert_strict_lvl0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_ok && !cpu_req && lvl_any[0]) |=> (gnt_valid && gnt_lvl == prio_t'(0)));
    assert_nofair_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_ok && !cpu_req && !fair_en && lvl_any[2]) |=> (gnt_valid && gnt_lvl <= prio_t'(2)));
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_gnt || gnt_valid) && !xfer_done) |=>
        ($stable(cpu_gnt) && $stable(gnt_valid) && $stable(gnt_idx) && $stable(gnt_onehot)));
endmodule

// File: tb/sim_dma_fair_arbiter.sv
// Self-checking bench: cycle model of the requirements plus directed sweeps.
module sim_dma_fair_arbiter;
    import dfa_pkg::*;

    localparam int N          = 24;
    localparam int IDX_W      = $clog2(N);
    localparam int CLK_PERIOD = 10;
    localparam int SLOTS      = 1 << SLOT_W;

    logic                clk;
    logic                rst_n;
    logic                cpu_req;
    logic [N-1:0]        ch_req;
    logic [N*PRIO_W-1:0] ch_prio;
    logic [N-1:0]        ch_rr_en;
    logic                fair_en;
    logic                xfer_done;
    logic                cpu_gnt;
    logic [N-1:0]        gnt_onehot;
    logic                gnt_valid;
    logic [IDX_W-1:0]    gnt_idx;

    int    tests = 0;
    int    fails = 0;
    int    prio_a [N];
    bit    m_cpu, m_valid;
    int    m_idx, m_lvl, m_cnt;
    int    m_ptr [NUM_LVL];
    string m_tag;

    dma_fair_arbiter #(.NUM_CH(N)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .ch_req(ch_req),
        .ch_prio(ch_prio), .ch_rr_en(ch_rr_en), .fair_en(fair_en),
        .xfer_done(xfer_done), .cpu_gnt(cpu_gnt), .gnt_onehot(gnt_onehot),
        .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pack_prio();
        for (int c = 0; c < N; c++) ch_prio[c*PRIO_W +: PRIO_W] = prio_t'(prio_a[c]);
    endtask

    // Model of one rising edge, built from the requirement text.
    task automatic model_edge();
        bit    has [NUM_LVL];
        int    hi, fav, lvl, pick, head;
        string ltag, ctag;
        if ((m_cpu || m_valid) && !xfer_done) begin m_tag = "R9 hold"; return; end
        if (cpu_req) begin m_cpu = 1; m_valid = 0; m_tag = "R1"; return; end
        m_cpu = 0;
        hi = -1;
        for (int l = NUM_LVL - 1; l >= 0; l--) begin
            has[l] = 0;
            for (int c = 0; c < N; c++) if (ch_req[c] && prio_a[c] == l) has[l] = 1;
            if (has[l]) hi = l;
        end
        if (hi < 0) begin m_valid = 0; m_tag = "R9 idle"; return; end
        fav = NUM_LVL - 1;
        for (int b = SLOT_W - 1; b >= 0; b--) if (((m_cnt >> b) & 1) == 1) fav = STRICT_LVLS + b;
        lvl  = hi;
        ltag = (hi < STRICT_LVLS) ? "R3" : (!fair_en ? "R6" : "R5");
        if (fair_en && hi >= STRICT_LVLS && has[fav]) begin lvl = fav; ltag = "R4"; end
        head = -1;
        for (int c = N - 1; c >= 0; c--) if (ch_req[c] && prio_a[c] == lvl && !ch_rr_en[c]) head = c;
        if (head >= 0) begin
            pick = head; ctag = "R8";
        end else begin
            pick = 0;
            for (int k = N - 1; k >= 0; k--) begin
                int j;
                j = (m_ptr[lvl] + k) % N;
                if (ch_req[j] && prio_a[j] == lvl) pick = j;
            end
            ctag = "R7";
            m_ptr[lvl] = (pick + 1) % N;
        end
        if (lvl >= STRICT_LVLS) m_cnt = (m_cnt + 1) % SLOTS;
        m_valid = 1; m_idx = pick; m_lvl = lvl;
        m_tag = {ltag, "/", ctag};
    endtask

    // One cycle: model the edge, let it pass, compare away from the edge.
    task automatic cycle();
        logic [N-1:0] exp_oh;
        model_edge();
        @(posedge clk);
        @(negedge clk);
        exp_oh = m_valid ? (N'(1) << m_idx) : '0;
        check({m_tag, " cpu_gnt"}, 64'(cpu_gnt), 64'(m_cpu));
        check({m_tag, " gnt_valid"}, 64'(gnt_valid), 64'(m_valid));
        if (m_valid) check({m_tag, " gnt_idx"}, 64'(gnt_idx), 64'(m_idx));
        check("R2 onehot", 64'(gnt_onehot), 64'(exp_oh));
    endtask

    task automatic do_reset();
        rst_n = 0; cpu_req = 0; ch_req = '0; ch_rr_en = '1; fair_en = 1; xfer_done = 0;
        for (int c = 0; c < N; c++) prio_a[c] = 7;
        pack_prio();
        repeat (3) @(posedge clk);
        @(negedge clk);
        m_cpu = 0; m_valid = 0; m_idx = 0; m_lvl = 0; m_cnt = 0;
        for (int l = 0; l < NUM_LVL; l++) m_ptr[l] = 0;
        check("R10 cpu_gnt", 64'(cpu_gnt), 0);
        check("R10 gnt_valid", 64'(gnt_valid), 0);
        check("R10 gnt_onehot", 64'(gnt_onehot), 0);
        check("R10 gnt_idx", 64'(gnt_idx), 0);
        rst_n = 1;
    endtask

    task automatic run_rand(int cycles, bit fair, int rr_pct, int cpu_pct, int strict_pct, int req_pct);
        for (int n = 0; n < cycles; n++) begin
            fair_en   = fair;
            cpu_req   = ($urandom_range(99) < cpu_pct);
            xfer_done = ($urandom_range(99) < 50);
            for (int c = 0; c < N; c++) begin
                ch_req[c]   = ($urandom_range(99) < req_pct);
                ch_rr_en[c] = ($urandom_range(99) < rr_pct);
                if (n % 7 == 0)
                    prio_a[c] = ($urandom_range(99) < strict_pct) ? $urandom_range(1)
                                                                  : $urandom_range(7, 2);
            end
            pack_prio();
            cycle();
        end
    endtask

    initial begin
        int got [NUM_LVL];
        do_reset();

        // R7: pointer starts at 0, then rotates among level-4 channels 1, 3, 20.
        prio_a[1] = 4; prio_a[3] = 4; prio_a[20] = 4; pack_prio();
        ch_req = '0; ch_req[1] = 1; ch_req[3] = 1; ch_req[20] = 1; xfer_done = 1;
        repeat (6) cycle();

        // R8: channels 3 and 20 opt out; 3 keeps winning and the pointer stays put.
        ch_rr_en[3] = 0; ch_rr_en[20] = 0;
        repeat (4) cycle();
        check("R8 head stays", 64'(gnt_idx), 3);
        ch_rr_en = '1;
        cycle();

        // R4: six fair levels always busy, 64 grants must split 32/16/8/4/2/2.
        do_reset();
        for (int c = 2; c < 8; c++) begin prio_a[c] = c; ch_req[c] = 1; end
        pack_prio(); xfer_done = 1; fair_en = 1;
        for (int l = 0; l < NUM_LVL; l++) got[l] = 0;
        for (int n = 0; n < SLOTS; n++) begin
            cycle();
            if (gnt_valid) got[gnt_idx]++;
        end
        for (int l = STRICT_LVLS; l < NUM_LVL; l++)
            check($sformatf("R4 share level %0d", l), 64'(got[l]),
                  64'((l < NUM_LVL - 1) ? (SLOTS >> (l - 1)) : 2));

        // R6: the same load with fairness off goes only to level 2.
        fair_en = 0;
        for (int l = 0; l < NUM_LVL; l++) got[l] = 0;
        for (int n = 0; n < 16; n++) begin cycle(); if (gnt_valid) got[gnt_idx]++; end
        check("R6 level 2 only", 64'(got[2]), 16);

        // R9: a level-0 request during a held grant waits for xfer_done.
        xfer_done = 0; prio_a[9] = 0; ch_req[9] = 1; pack_prio();
        repeat (3) cycle();
        check("R9 held owner", 64'(gnt_idx), 2);
        xfer_done = 1; cycle();
        check("R3 level 0 after done", 64'(gnt_idx), 9);
        // R1: processor request at the transaction end.
        cpu_req = 1; cycle();
        check("R1 cpu owns", 64'(cpu_gnt), 1);
        cpu_req = 0; ch_req = '0; cycle();
        check("R9 idle clears", 64'(gnt_valid), 0);

        // Random sweeps over mixed conditions.
        do_reset();
        run_rand(1500, 1, 90, 5, 10, 20);
        run_rand(1000, 0, 80, 5, 10, 25);
        run_rand(1000, 1, 50, 20, 30, 10);
        run_rand(1000, 1, 100, 0, 0, 40);
        run_rand(500, 1, 70, 2, 5, 3);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule